// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the register through which software talks to an Ethernet PHY over the management bus. Software writes one 32-bit command word. The word holds a data field, a PHY register address, a PHY address, an operation code and an interrupt-on-complete request. The block does not drive any serial management signalling. On the clock after the command is captured, it completes the command. A read of one of a small set of PHY registers returns a fixed value that describes a gigabit, full-duplex PHY with the link up. The block then sets the ready bit, so a polling driver sees the access finish.

Only one PHY address is served. A command aimed at any other PHY address, or one that asks for a completion interrupt, is still completed with ready. It raises an error flag, and the data field is left as written. A read of a register outside the fixed set returns zero and raises a warning flag. A write operation changes nothing in the PHY model; it only completes.

Top module: `mgmt_phy_resp`

## Requirements
- R1: While reset is asserted, and after it is released, the command word reads 0 and all three flags are low.
- R2: The command word fields are: data in bits 15:0, PHY register address in bits 20:16, PHY address in bits 25:21, operation in bits 27:26 (01 write, 10 read, 00 and 11 reserved), ready in bit 28, interrupt request in bit 29, and bits 31:30 spare. On the clock edge that samples `cmd_wr` high, the word is captured as written, except that ready is forced to 0.
- R3: On the next clock edge, if no new command is written, ready is set. Any data update and the flag values appear in that same edge.
- R4: A read at PHY address 1 with the interrupt bit clear returns these fixed values: register 1 gives 0x796D, register 2 gives 0x02A8, register 3 gives 0x0380, register 10 gives 0x7C00, register 15 gives 0x3000 and register 18 gives 0x0180. `warn_unmapped` stays low.
- R5: A read at PHY address 1, with the interrupt bit clear, of any other register returns 0 in the data field and sets `warn_unmapped`.
- R6: A command at a PHY address other than 1 sets `err_phy_addr` and still sets ready. The data field stays as written and no warning is raised.
- R7: A command with the interrupt bit set sets `err_irq_req` and still sets ready. The data field stays as written. R6 and R7 may apply to the same command together.
- R8: A write operation, or a reserved operation, leaves the data field as written and raises no warning, even for an unmapped register.
- R9: The flags are low whenever ready is low. After completion, the word and the flags hold until the next command is written.
- R10: A command written in the completion cycle of an earlier one supersedes it. The earlier command never reports ready, and the later one completes one clock after its own capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_word | input | 32 | Command word written by software |
| mgmt_word | output | 32 | Current register value, polled by software |
| err_phy_addr | output | 1 | Completed command targeted an unsupported PHY address |
| err_irq_req | output | 1 | Completed command asked for a completion interrupt |
| warn_unmapped | output | 1 | Completed read targeted a register outside the fixed set |

## Verification
Every result is due at a fixed cycle offset from the strobe. The captured word with ready cleared appears one edge after `cmd_wr` is sampled. Ready, the returned data and the flags appear one edge after that. The bench drives each command on a falling edge and drops the strobe on the next falling edge, where it checks the cleared state. It checks the completed state one falling edge later, so every comparison is taken half a period after the edge that produced it. The superseding case and the hold-while-idle case reuse the same counting, with extra falling edges inserted.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

  localparam int WORD_W = 32;
  localparam int DATA_W = 16;
  localparam int REGA_W = 5;
  localparam int PHYA_W = 5;
  localparam int NUM_ENTRIES = 6;

  typedef enum logic [1:0] {
    OP_RSV0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSV3  = 2'b11
  } mgmt_op_e;

  typedef struct packed {
    logic [1:0]        spare;
    logic              irq_en;
    logic              ready;
    mgmt_op_e          op;
    logic [PHYA_W-1:0] phy;
    logic [REGA_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } mgmt_word_t;

  function automatic logic [REGA_W-1:0] tbl_addr(input int idx);
    logic [REGA_W-1:0] a;
    case (idx)
      0:       a = REGA_W'(1);
      1:       a = REGA_W'(2);
      2:       a = REGA_W'(3);
      3:       a = REGA_W'(10);
      4:       a = REGA_W'(15);
      default: a = REGA_W'(18);
    endcase
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] tbl_value(input int idx);
    logic [DATA_W-1:0] v;
    case (idx)
      0:       v = 16'h796D;
      1:       v = 16'h02A8;
      2:       v = 16'h0380;
      3:       v = 16'h7C00;
      4:       v = 16'h3000;
      default: v = 16'h0180;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mgmt_cmd_check.sv
module mgmt_cmd_check
  import mgmt_phy_pkg::*;
#(
  parameter int unsigned SUPPORTED_PHY = 1
) (
  input  logic [PHYA_W-1:0] phy,
  input  mgmt_op_e          op,
  input  logic              irq_en,
  output logic              bad_phy,
  output logic              irq_req,
  output logic              is_read
);

  localparam logic [PHYA_W-1:0] PHY_OK = PHYA_W'(SUPPORTED_PHY);

  always_comb begin
    bad_phy = (phy != PHY_OK);
    irq_req = irq_en;
    is_read = (op == OP_READ);
  end

endmodule

// File: rtl/mgmt_phy_table.sv
module mgmt_phy_table
  import mgmt_phy_pkg::*;
(
  input  logic [REGA_W-1:0] regad,
  output logic              hit,
  output logic [DATA_W-1:0] value
);

  logic [NUM_ENTRIES-1:0] match;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
    assign match[gi] = (regad == tbl_addr(gi));
  end

  always_comb begin
    value = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      value = value | (match[i] ? tbl_value(i) : '0);
    end
    hit = |match;
  end

endmodule

// File: rtl/mgmt_resp_reg.sv
module mgmt_resp_reg
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  mgmt_word_t        cmd_word,
  input  logic              bad_phy,
  input  logic              irq_req,
  input  logic              is_read,
  input  logic              tbl_hit,
  input  logic [DATA_W-1:0] tbl_value,
  output mgmt_word_t        word_q,
  output logic              err_phy_q,
  output logic              err_irq_q,
  output logic              warn_q
);

  mgmt_word_t word_d;
  logic       pend_q, pend_d;
  logic       err_phy_d, err_irq_d, warn_d;
  logic       ld_en;

  assign ld_en = cmd_wr | pend_q;

  always_comb begin
    word_d    = word_q;
    pend_d    = pend_q;
    err_phy_d = err_phy_q;
    err_irq_d = err_irq_q;
    warn_d    = warn_q;
    if (cmd_wr) begin
      word_d       = cmd_word;
      word_d.ready = 1'b0;
      pend_d       = 1'b1;
      err_phy_d    = 1'b0;
      err_irq_d    = 1'b0;
      warn_d       = 1'b0;
    end else if (pend_q) begin
      pend_d       = 1'b0;
      word_d.ready = 1'b1;
      err_phy_d    = bad_phy;
      err_irq_d    = irq_req;
      warn_d       = 1'b0;
      if (!bad_phy && !irq_req && is_read) begin
        word_d.data = tbl_hit ? tbl_value : '0;
        warn_d      = !tbl_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      pend_q    <= 1'b0;
      err_phy_q <= 1'b0;
      err_irq_q <= 1'b0;
      warn_q    <= 1'b0;
    end else if (ld_en) begin
      word_q    <= word_d;
      pend_q    <= pend_d;
      err_phy_q <= err_phy_d;
      err_irq_q <= err_irq_d;
      warn_q    <= warn_d;
    end
  end

endmodule

// File: rtl/mgmt_phy_resp.sv
module mgmt_phy_resp
  import mgmt_phy_pkg::*;
#(
  parameter int unsigned SUPPORTED_PHY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_word,
  output logic [WORD_W-1:0] mgmt_word,
  output logic              err_phy_addr,
  output logic              err_irq_req,
  output logic              warn_unmapped
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  mgmt_word_t        word_q;
  logic              bad_phy, irq_req, is_read, tbl_hit;
  logic [DATA_W-1:0] tbl_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  mgmt_cmd_check #(.SUPPORTED_PHY(SUPPORTED_PHY)) u_check (
    .phy     (word_q.phy),
    .op      (word_q.op),
    .irq_en  (word_q.irq_en),
    .bad_phy (bad_phy),
    .irq_req (irq_req),
    .is_read (is_read)
  );

  mgmt_phy_table u_table (
    .regad (word_q.regad),
    .hit   (tbl_hit),
    .value (tbl_value)
  );

  mgmt_resp_reg u_resp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_wr    (cmd_wr),
    .cmd_word  (mgmt_word_t'(cmd_word)),
    .bad_phy   (bad_phy),
    .irq_req   (irq_req),
    .is_read   (is_read),
    .tbl_hit   (tbl_hit),
    .tbl_value (tbl_value),
    .word_q    (word_q),
    .err_phy_q (err_phy_addr),
    .err_irq_q (err_irq_req),
    .warn_q    (warn_unmapped)
  );

  assign mgmt_word = word_q;

endmodule

// File: rtl/mgmt_phy_resp_chk.sv
module mgmt_phy_resp_chk #(
  parameter int unsigned SUPPORTED_PHY = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] mgmt_word,
  input logic        err_phy_addr,
  input logic        err_irq_req,
  input logic        warn_unmapped
);

  AST_CMD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !mgmt_word[28]); // R2

  AST_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && $past(cmd_wr)) |=> mgmt_word[28]); // R3

  AST_BAD_PHY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_word[28] && mgmt_word[25:21] != 5'(SUPPORTED_PHY)) |-> err_phy_addr); // R6

  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_word[28] && mgmt_word[29]) |-> err_irq_req); // R7

  AST_WARN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    warn_unmapped |-> (mgmt_word[15:0] == 16'h0000)); // R5

  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_word[28] |-> !(err_phy_addr || err_irq_req || warn_unmapped)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_word[28] && !cmd_wr) |=> $stable(mgmt_word)); // R9

endmodule

bind mgmt_phy_resp mgmt_phy_resp_chk #(.SUPPORTED_PHY(SUPPORTED_PHY)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cmd_wr        (cmd_wr),
  .mgmt_word     (mgmt_word),
  .err_phy_addr  (err_phy_addr),
  .err_irq_req   (err_irq_req),
  .warn_unmapped (warn_unmapped)
);

// File: tb/test_mgmt_phy_resp.sv
`timescale 1ns/1ps
module test_mgmt_phy_resp;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr;
  logic [31:0] cmd_word;
  logic [31:0] mgmt_word;
  logic        err_phy_addr, err_irq_req, warn_unmapped;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mgmt_phy_resp i_mgmt_phy_resp (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_wr        (cmd_wr),
    .cmd_word      (cmd_word),
    .mgmt_word     (mgmt_word),
    .err_phy_addr  (err_phy_addr),
    .err_irq_req   (err_irq_req),
    .warn_unmapped (warn_unmapped)
  );

  function automatic logic [31:0] mk(input logic [4:0] phy, input logic [4:0] ra,
                                     input logic [1:0] op, input logic irq,
                                     input logic [15:0] d, input logic rdy);
    return {2'b00, irq, rdy, op, phy, ra, d};
  endfunction

  task automatic chk(input string rq, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [34:0] observed();
    return {mgmt_word, err_phy_addr, err_irq_req, warn_unmapped};
  endfunction

  // drive a command, check the cleared state, then the completed state
  task automatic run_cmd(input string rq, input logic [31:0] w,
                         input logic [15:0] exp_data, input logic ep,
                         input logic ei, input logic wn);
    logic [31:0] cap;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    cap = w; cap[28] = 1'b0;
    chk({rq, " R2 capture"}, observed(), {cap, 3'b000});
    @(negedge clk);
    cap[28] = 1'b1; cap[15:0] = exp_data;
    chk({rq, " R3 complete"}, observed(), {cap, ep, ei, wn});
  endtask

  task automatic t_reset();
    chk("R1 in reset", observed(), 35'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", observed(), 35'd0);
  endtask

  task automatic t_table();
    run_cmd("R4 reg1",  mk(5'd1, 5'd1,  2'b10, 1'b0, 16'hFFFF, 1'b1), 16'h796D, 0, 0, 0);
    run_cmd("R4 reg2",  mk(5'd1, 5'd2,  2'b10, 1'b0, 16'h1234, 1'b0), 16'h02A8, 0, 0, 0);
    run_cmd("R4 reg3",  mk(5'd1, 5'd3,  2'b10, 1'b0, 16'h0000, 1'b0), 16'h0380, 0, 0, 0);
    run_cmd("R4 reg10", mk(5'd1, 5'd10, 2'b10, 1'b0, 16'hAAAA, 1'b0), 16'h7C00, 0, 0, 0);
    run_cmd("R4 reg15", mk(5'd1, 5'd15, 2'b10, 1'b0, 16'h5555, 1'b0), 16'h3000, 0, 0, 0);
    run_cmd("R4 reg18", mk(5'd1, 5'd18, 2'b10, 1'b0, 16'h0F0F, 1'b0), 16'h0180, 0, 0, 0);
  endtask

  task automatic t_unmapped();
    run_cmd("R5 reg0",  mk(5'd1, 5'd0,  2'b10, 1'b0, 16'hBEEF, 1'b0), 16'h0000, 0, 0, 1);
    run_cmd("R5 reg31", mk(5'd1, 5'd31, 2'b10, 1'b0, 16'h1111, 1'b0), 16'h0000, 0, 0, 1);
  endtask

  task automatic t_bad_phy();
    run_cmd("R6 phy0",  mk(5'd0,  5'd1, 2'b10, 1'b0, 16'hC0DE, 1'b0), 16'hC0DE, 1, 0, 0);
    run_cmd("R6 phy31", mk(5'd31, 5'd7, 2'b10, 1'b0, 16'h0042, 1'b0), 16'h0042, 1, 0, 0);
  endtask

  task automatic t_irq();
    run_cmd("R7 irq",      mk(5'd1, 5'd1, 2'b10, 1'b1, 16'h7777, 1'b0), 16'h7777, 0, 1, 0);
    run_cmd("R7 irq+phy",  mk(5'd2, 5'd2, 2'b01, 1'b1, 16'h8888, 1'b0), 16'h8888, 1, 1, 0);
  endtask

  task automatic t_write_op();
    run_cmd("R8 write mapped",   mk(5'd1, 5'd1,  2'b01, 1'b0, 16'h1357, 1'b0), 16'h1357, 0, 0, 0);
    run_cmd("R8 write unmapped", mk(5'd1, 5'd9,  2'b01, 1'b0, 16'h2468, 1'b0), 16'h2468, 0, 0, 0);
    run_cmd("R8 op00",           mk(5'd1, 5'd2,  2'b00, 1'b0, 16'h0101, 1'b0), 16'h0101, 0, 0, 0);
    run_cmd("R8 op11",           mk(5'd1, 5'd20, 2'b11, 1'b0, 16'h0202, 1'b0), 16'h0202, 0, 0, 0);
  endtask

  task automatic t_hold();
    logic [31:0] e;
    run_cmd("R9 setup", mk(5'd1, 5'd4, 2'b10, 1'b0, 16'h9999, 1'b0), 16'h0000, 0, 0, 1);
    repeat (5) @(negedge clk);
    e = mk(5'd1, 5'd4, 2'b10, 1'b0, 16'h0000, 1'b1);
    chk("R9 hold idle", observed(), {e, 3'b001});
    run_cmd("R9 flags cleared", mk(5'd1, 5'd3, 2'b10, 1'b0, 16'h0000, 1'b0), 16'h0380, 0, 0, 0);
  endtask

  task automatic t_supersede();
    logic [31:0] b;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = mk(5'd0, 5'd0, 2'b10, 1'b1, 16'hDEAD, 1'b0);
    @(negedge clk);
    cmd_word = mk(5'd1, 5'd15, 2'b10, 1'b0, 16'h4321, 1'b0);
    @(negedge clk);
    cmd_wr = 1'b0;
    b = cmd_word;
    chk("R10 first superseded", observed(), {b, 3'b000});
    @(negedge clk);
    b[28] = 1'b1; b[15:0] = 16'h3000;
    chk("R10 second completes", observed(), {b, 3'b000});
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_word = '0;
    #1;
    t_reset();
    t_table();
    t_unmapped();
    t_bad_phy();
    t_irq();
    t_write_op();
    t_hold();
    t_supersede();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule